// File: doc/BRIEF.md
# Block-Write Configuration Target on a Two-Wire Serial Bus

This block is a standard-mode two-wire serial bus target that keeps a small bank of 8-bit configuration bytes and presents them to the rest of the chip as one parallel vector. It answers at the 7-bit address 69h: the address byte D2h opens a write and D3h opens a read. It supports at most 100 kbit/s. The block drives SDA only by pulling it low, and it never stretches the clock.

Register addressing does not exist. A write carries a command byte and then a count byte. The target acknowledges both and discards their contents. Each data byte that follows fills the next register, starting at register 0. The host may stop after any whole byte, and registers it did not reach keep their old values. A read first returns the number of registers and then every register in ascending order, until the host answers with a NACK.

The whole protocol runs in the system clock domain. SCL and SDA are first resynchronised, and the block then looks for edges and bus conditions on the synchronised copies. For this to work, the system clock must be many times faster than SCL.

Top module: `cfg_i2c_target`

## Requirements
- R1: The target acknowledges the address bytes D2h (write) and D3h (read), which are the 7-bit address 69h plus the R/W bit. It does not acknowledge any other address, and the rest of that transfer has no effect on the registers.
- R2: In a write, the first two bytes after the address are a command byte and a count byte. Both are acknowledged, and neither is stored in any register.
- R3: Data bytes after the count byte are stored in register 0, then register 1, and so on in ascending order. Each byte is acknowledged, is received MSB first, and appears in cfg_o bits [8k+7:8k] for register k.
- R4: A Stop after any complete data byte ends the write. Registers that the write did not reach keep their previous values.
- R5: A read returns the register count (6 with default parameters) as its first byte, followed by registers 0, 1, 2 and onward. Each byte is sent MSB first.
- R6: When the host NACKs a read byte, the target releases SDA and sends nothing further until the next Start.
- R7: After reset, registers 0 to 2 (the output-enable bytes) hold FFh and registers 3 to 5 hold 00h.
- R8: A Stop or a repeated Start that arrives in the middle of a byte discards the partial byte. The target then waits for an address, and a Start followed by a valid transfer is served normally.
- R9: Data bytes beyond the last register are still acknowledged but change no register.
- R10: The target pulls SDA low only when SCL is low (its ACK or read data). It releases SDA whenever it is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, far faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| cfg_o | output | NUM_REGS*8 | All configuration bytes, register k in bits [8k+7:8k] |

## Verification
The assertions assume a well-behaved host. Such a host changes SDA only while SCL is low, except when it signals a Start or a Stop. It also holds each SCL phase for many system clocks, so the synchronisers never see SCL and SDA move in the same cycle. The bench host places every SDA change a quarter bit after the SCL fall and every sample in the middle of the high phase. All host activity is aligned to falling system-clock edges. The one mid-byte Stop and the one repeated Start are built from those same legal edges.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } tgt_state_t;

    // Bus events seen after resynchronisation.
    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Write request from the protocol engine to the register bank.
    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [7:0] data;
    } reg_wr_t;

    function automatic logic [7:0] reset_value(int idx, int num_en);
        return (idx < num_en) ? 8'hFF : 8'h00;
    endfunction

    function automatic logic [7:0] sat_inc(logic [7:0] cur, logic [7:0] lim);
        return (cur >= lim) ? cur : cur + 8'd1;
    endfunction

endpackage

// File: rtl/cfg_i2c_lines.sv
module cfg_i2c_lines
    import cfg_i2c_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [2:0] scl_sh;
    logic [2:0] sda_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= 3'b111;
            sda_sh <= 3'b111;
        end else begin
            scl_sh <= {scl_sh[1:0], scl_i};
            sda_sh <= {sda_sh[1:0], sda_i};
        end
    end

    always_comb begin
        ev.scl   = scl_sh[1];
        ev.sda   = sda_sh[1];
        ev.rise  = scl_sh[1] & ~scl_sh[2];
        ev.fall  = ~scl_sh[1] & scl_sh[2];
        ev.start = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
        ev.stop  = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];
    end

    // R8: bus conditions and clock edges are mutually exclusive
    a_r8_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.start, ev.stop, ev.rise, ev.fall}));

endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS    = 6,
    parameter int NUM_EN_REGS = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  reg_wr_t                  wr,
    output logic [NUM_REGS-1:0][7:0] q
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= reset_value(g, NUM_EN_REGS);
            else if (wr.en && wr.idx == 8'(g))
                q[g] <= wr.data;
        end
    end

    // R2/R4: without a write request no register moves
    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(q));

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
    import cfg_i2c_pkg::*;
#(
    parameter int         NUM_REGS    = 6,
    parameter int         NUM_EN_REGS = 3,
    parameter logic [6:0] DEV_ADDR    = 7'h69
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam logic [7:0] IDX_LIMIT = 8'(NUM_REGS + 2);
    localparam logic [7:0] COUNT_VAL = 8'(NUM_REGS);

    bus_ev_t                  ev;
    reg_wr_t                  wr_q;
    logic [NUM_REGS-1:0][7:0] regs_q;

    tgt_state_t state;
    logic [2:0] bit_cnt;
    logic       byte_full;
    logic [7:0] sh_in;
    logic [7:0] tx_sr;
    logic [7:0] byte_idx;
    logic       is_read;
    logic       nack;
    logic [7:0] rd_sel;

    cfg_i2c_lines u_lines (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    cfg_i2c_regs #(
        .NUM_REGS    (NUM_REGS),
        .NUM_EN_REGS (NUM_EN_REGS)
    ) u_regs (
        .clk (clk),
        .rst (rst),
        .wr  (wr_q),
        .q   (regs_q)
    );

    assign cfg_o = regs_q;

    // Read byte: count first, then registers, zero past the end.
    always_comb begin
        rd_sel = 8'h00;
        if (byte_idx == 8'd0)
            rd_sel = COUNT_VAL;
        for (int k = 0; k < NUM_REGS; k++)
            if (byte_idx == 8'(k + 1))
                rd_sel = regs_q[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            byte_full <= 1'b0;
            sh_in     <= '0;
            tx_sr     <= '0;
            byte_idx  <= '0;
            is_read   <= 1'b0;
            nack      <= 1'b0;
            sda_oe    <= 1'b0;
            wr_q      <= '0;
        end else begin
            wr_q.en <= 1'b0;
            if (ev.start) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                byte_full <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (ev.stop) begin
                state     <= ST_IDLE;
                byte_full <= 1'b0;
                sda_oe    <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: sda_oe <= 1'b0;
                    ST_ADDR, ST_WR_BYTE: begin
                        if (ev.rise && !byte_full) begin
                            sh_in <= {sh_in[6:0], ev.sda};
                            if (bit_cnt == 3'd7) byte_full <= 1'b1;
                            else                 bit_cnt   <= bit_cnt + 3'd1;
                        end else if (ev.fall && byte_full) begin
                            byte_full <= 1'b0;
                            bit_cnt   <= '0;
                            if (state == ST_ADDR) begin
                                if (sh_in[7:1] == DEV_ADDR) begin
                                    state    <= ST_ADDR_ACK;
                                    sda_oe   <= 1'b1;
                                    is_read  <= sh_in[0];
                                    byte_idx <= '0;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                state  <= ST_WR_ACK;
                                sda_oe <= 1'b1;
                                if (byte_idx >= 8'd2 && byte_idx < IDX_LIMIT) begin
                                    wr_q.en   <= 1'b1;
                                    wr_q.idx  <= byte_idx - 8'd2;
                                    wr_q.data <= sh_in;
                                end
                                byte_idx <= sat_inc(byte_idx, IDX_LIMIT);
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_WR_ACK: begin
                        if (ev.fall) begin
                            if (state == ST_ADDR_ACK && is_read) begin
                                state    <= ST_RD_BYTE;
                                tx_sr    <= rd_sel;
                                sda_oe   <= ~rd_sel[7];
                                byte_idx <= sat_inc(byte_idx, IDX_LIMIT);
                            end else begin
                                state  <= ST_WR_BYTE;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev.fall) begin
                            if (bit_cnt == 3'd7) begin
                                state   <= ST_RD_ACK;
                                bit_cnt <= '0;
                                sda_oe  <= 1'b0;
                            end else begin
                                bit_cnt <= bit_cnt + 3'd1;
                                tx_sr   <= {tx_sr[6:0], 1'b0};
                                sda_oe  <= ~tx_sr[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.rise) begin
                            nack <= ev.sda;
                        end else if (ev.fall) begin
                            if (nack) begin
                                state <= ST_IDLE;
                            end else begin
                                state    <= ST_RD_BYTE;
                                tx_sr    <= rd_sel;
                                sda_oe   <= ~rd_sel[7];
                                byte_idx <= sat_inc(byte_idx, IDX_LIMIT);
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R10: the target only starts pulling SDA while SCL is low
    a_r10_pull_on_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    // R10: SDA released in idle
    a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE |-> !sda_oe);

    // R8: a Stop always returns the engine to idle
    a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> state == ST_IDLE);

    // R8: a Start always restarts address reception
    a_r8_start_to_addr: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> state == ST_ADDR && bit_cnt == 3'd0);

    // R1: address acknowledge is actually driven
    a_r1_ack_driven: assert property (@(posedge clk) disable iff (rst)
        state == ST_ADDR_ACK |-> sda_oe);

    // R6: the host's acknowledge slot is left free
    a_r6_ack_slot_free: assert property (@(posedge clk) disable iff (rst)
        state == ST_RD_ACK |-> !sda_oe);

    // R9: no write request ever targets a missing register
    a_r9_write_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_q.en |-> wr_q.idx < 8'(NUM_REGS));

endmodule

// File: tb/cfg_i2c_target_tb.sv
`timescale 1ns/1ps
module cfg_i2c_target_tb_top;
    localparam int NREG = 6;
    localparam time Q   = 200ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic sda;
    logic [NREG*8-1:0] cfg;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int r10_bad = 0;
    bit done = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] model [NREG];

    always #10ns clk = ~clk;

    assign sda = sda_h & ~sda_oe;

    cfg_i2c_target dut_i (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda),
        .sda_oe (sda_oe),
        .cfg_o  (cfg)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        prev_oe <= sda_oe;
        if (!rst && sda_oe && !prev_oe && scl) r10_bad <= r10_bad + 1;
        if (cyc == 150000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        scl = 0; #Q; sda_h = 1; #Q; scl = 1; #Q; sda_h = 0; #Q; scl = 0; #Q;
    endtask

    task automatic bus_stop();
        scl = 0; sda_h = 0; #Q; scl = 1; #Q; sda_h = 1; #Q;
    endtask

    task automatic put_bit(input logic b);
        sda_h = b; #Q; scl = 1; #(2*Q); scl = 0; #Q;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_h = 1; #Q; scl = 1; #Q; ack = sda; #Q; scl = 0; #Q;
    endtask

    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            sda_h = 1; #Q; scl = 1; #Q; b = {b[6:0], sda}; #Q; scl = 0; #Q;
        end
        put_bit(host_ack);
    endtask

    task automatic check_cfg(input string req);
        for (int k = 0; k < NREG; k++) chk(cfg[8*k +: 8], model[k], req);
    endtask

    task automatic block_write(input int n, input logic [7:0] base, input string req);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk(a, 0, "R1 write address ack");
        send_byte(8'h5A, a); chk(a, 0, "R2 command ack");
        send_byte(8'h06, a); chk(a, 0, "R2 count ack");
        for (int i = 0; i < n; i++) begin
            send_byte(base + 8'(i * 17), a);
            chk(a, 0, req);
            if (i < NREG) model[i] = base + 8'(i * 17);
        end
        bus_stop();
        #Q;
    endtask

    task automatic test_reset();
        for (int k = 0; k < NREG; k++) model[k] = (k < 3) ? 8'hFF : 8'h00;
        check_cfg("R7 reset values");
        chk(sda_oe, 0, "R10 released after reset");
    endtask

    task automatic test_read(input string req);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, a); chk(a, 0, "R1 read address ack");
        recv_byte(0, b); chk(b, NREG, "R5 byte count");
        for (int k = 0; k < NREG; k++) begin
            recv_byte(k == NREG - 1, b);
            chk(b, model[k], req);
        end
        #Q;
        chk(sda, 1, "R6 SDA released after NACK");
        chk(sda_oe, 0, "R6 no drive after NACK");
        bus_stop();
        chk(sda_oe, 0, "R10 released in idle");
    endtask

    task automatic test_full_write();
        block_write(NREG, 8'h11, "R3 data ack");
        check_cfg("R3 R2 stored in order, command and count not stored");
    endtask

    task automatic test_partial_write();
        block_write(2, 8'hA1, "R4 data ack");
        check_cfg("R4 unreached registers kept");
    endtask

    task automatic test_overflow_write();
        block_write(NREG + 2, 8'h30, "R9 overflow bytes acked");
        check_cfg("R9 overflow has no effect");
    endtask

    task automatic test_wrong_addr();
        logic a;
        bus_start();
        send_byte(8'hA4, a); chk(a, 1, "R1 foreign address not acked");
        send_byte(8'h00, a); chk(a, 1, "R1 no ack after foreign address");
        send_byte(8'h99, a);
        bus_stop();
        check_cfg("R1 foreign transfer ignored");
    endtask

    task automatic test_mid_byte();
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h06, a);
        put_bit(1); put_bit(0); put_bit(1);
        bus_stop();
        #Q;
        check_cfg("R8 partial byte before Stop discarded");
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h06, a);
        put_bit(0); put_bit(1); put_bit(1); put_bit(0);
        bus_start();
        send_byte(8'hD2, a); chk(a, 0, "R8 address acked after repeated Start");
        send_byte(8'h00, a);
        send_byte(8'h06, a);
        send_byte(8'hC3, a); chk(a, 0, "R8 data acked after repeated Start");
        bus_stop();
        #Q;
        model[0] = 8'hC3;
        check_cfg("R8 partial byte before repeated Start discarded");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        test_reset();
        test_read("R5 R7 default read data");
        test_full_write();
        test_partial_write();
        test_overflow_write();
        test_wrong_addr();
        test_mid_byte();
        test_read("R5 read after writes");
        chk(r10_bad, 0, "R10 pull started only while SCL low");
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule